// File: doc/BRIEF.md
# Planar-to-Palette Pixel Serializer

This block turns one byte from each of four display-memory planes into a sequence of eight 4-bit values for a colour lookup stage. A single 2-bit format field picks how the bits are gathered. In the **planar** format, every transfer takes the same bit position from all four planes, giving one 16-colour pixel. In the **interleaved** format, each transfer carries two 2-colour-bit pixels. A pair of adjacent bits comes from one plane of a plane pair, and the pair changes half-way through the group.

The format field lives in a mode register that software reaches through two ports: an index port and a data port. The plane bytes enter on a valid/ready stream. Each accepted beat (a load) starts a new group of eight transfers. The output is also a valid/ready stream, and its ready acts as the pixel-clock enable. `in_ready` rises again during the eighth transfer, when that transfer is being taken, so the next group can follow with no idle cycle. Back-pressure rules:
- A stalled output (`out_valid` high, `out_ready` low) holds its value and its position in the group.
- The input is never accepted while a group still has untaken transfers beyond the current one.

Top module: `vga_plane_serializer`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, and both the index register and the mode register read back as 0.
- R2: A write with `cfg_sel`=0 stores `cfg_wdata` as the index. A write with `cfg_sel`=1 stores all 8 data bits into the mode register only when the index is 5. With any other index the write is ignored, and a read with `cfg_sel`=1 returns 0. A read with `cfg_sel`=0 returns the index.
- R3: A load happens when `in_valid` and `in_ready` are both high at a clock edge. It captures the four plane bytes (plane n at `in_planes[8n+7:8n]`), captures the format field, and makes transfer 1 visible on `out_pix` with `out_valid` high after that edge.
- R4: With mode register bits 6..5 equal to 00, transfer k (k = 1..8) drives `out_pix[n]` = plane n, bit 8-k.
- R5: With bits 6..5 equal to 01, transfers 1..4 use bit pairs (7,6), (5,4), (3,2), (1,0) in that order. `out_pix[1]` and `out_pix[0]` take the odd and even bit of plane 0. `out_pix[3]` and `out_pix[2]` take the odd and even bit of plane 2.
- R6: With bits 6..5 equal to 01, transfers 5..8 repeat the same pair order, using plane 1 for `out_pix[1:0]` and plane 3 for `out_pix[3:2]`.
- R7: Field values 10 and 11 produce the same output as 00.
- R8: The group advances by one transfer only on a cycle where `out_valid` and `out_ready` are both high. While stalled, `out_pix` and `out_valid` hold.
- R9: `in_ready` is 1 when no transfer is pending, and also during transfer 8 while `out_ready` is high. It is 0 otherwise, so back-to-back groups have no gap.
- R10: A mode register write during a group does not change that group. The new format applies from the next load.
- R11: Mode register bits other than 6..5 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read data of the port chosen by `cfg_sel` |
| in_valid | input | 1 | Plane bytes available |
| in_ready | output | 1 | Request for the next set of plane bytes |
| in_planes | input | 32 | Four plane bytes, plane n in bits 8n+7..8n |
| out_valid | output | 1 | A transfer is presented |
| out_ready | input | 1 | Pixel-clock enable: takes the current transfer |
| out_pix | output | 4 | 4-bit value for the colour lookup |

## Verification
The bench goes after the half-group plane swap in the interleaved format. A design that misses the swap repeats planes 0/2 for all eight transfers, and one with a swapped bit order inside a pair shows mirrored 2-bit pixels. It drives the output with random stalls, including a stall on transfer 8 with a load waiting. A block that advanced or reloaded there would drop or repeat a transfer, and a `in_ready` tied only to idle would show a one-cycle bubble between groups. It also rewrites the format in the middle of groups, which would corrupt the running group in a design that decoded the live register. Finally it uses field values 10/11, other nonzero register bits and writes through a wrong index. A careless decoder would turn these into odd output or a changed format.

// File: rtl/vga_ser_pkg.sv
package vga_ser_pkg;

  localparam int PLANES = 4;

  typedef enum logic [1:0] {
    FMT_PLANAR  = 2'b00,
    FMT_ODDEVEN = 2'b01,
    FMT_RSV_A   = 2'b10,
    FMT_RSV_B   = 2'b11
  } fmt_e;

  // Formats outside scope fall back to planar.
  function automatic fmt_e fmt_normalize(input fmt_e f);
    return (f == FMT_ODDEVEN) ? FMT_ODDEVEN : FMT_PLANAR;
  endfunction

endpackage

// File: rtl/vga_ser_cfg.sv
module vga_ser_cfg
  import vga_ser_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 8,
  parameter int MODE_IDX  = 5,
  parameter int FIELD_LSB = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output fmt_e              fmt
);

  localparam logic [IDX_W-1:0] MODE_IDX_V = IDX_W'(MODE_IDX);

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] mode_q;
  logic              hit;

  assign hit = (idx_q == MODE_IDX_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mode_q <= '0;
    end else if (wr_en) begin
      if (!sel) begin
        idx_q <= wdata[IDX_W-1:0];
      end else if (hit) begin
        mode_q <= wdata;
      end
    end
  end

  always_comb begin
    if (sel) begin
      rdata = hit ? mode_q : '0;
    end else begin
      rdata = DATA_W'(idx_q);
    end
  end

  assign fmt = fmt_e'(mode_q[FIELD_LSB +: 2]);

  AST_DATA_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel && hit) |=> (mode_q == $past(wdata))); // R2
  AST_FOREIGN_IDX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel && !hit) |=> $stable(mode_q)); // R2

endmodule

// File: rtl/vga_ser_seq.sv
module vga_ser_seq
  import vga_ser_pkg::*;
#(
  parameter int GROUP = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  output logic                     out_valid,
  input  logic                     out_ready,
  input  fmt_e                     fmt_in,
  output logic                     load,
  output logic [$clog2(GROUP)-1:0] cnt,
  output fmt_e                     fmt_q
);

  localparam int                CNT_W = $clog2(GROUP);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(GROUP - 1);

  logic valid_q;
  logic fire;
  logic last;

  assign last      = (cnt == LAST);
  assign fire      = valid_q && out_ready;
  assign in_ready  = !valid_q || (last && out_ready);
  assign load      = in_valid && in_ready;
  assign out_valid = valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      cnt     <= '0;
      fmt_q   <= FMT_PLANAR;
    end else if (load) begin
      valid_q <= 1'b1;
      cnt     <= '0;
      fmt_q   <= fmt_normalize(fmt_in);
    end else if (fire) begin
      if (last) begin
        valid_q <= 1'b0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  AST_NO_REQ_MIDGROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !last) |-> !in_ready); // R9
  AST_LOAD_STARTS_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (valid_q && cnt == '0)); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !out_ready) |=> (valid_q && $stable(cnt))); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !last) |=> (cnt == $past(cnt) + CNT_W'(1))); // R8
  AST_FMT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !load) |=> $stable(fmt_q)); // R10

endmodule

// File: rtl/vga_ser_mux.sv
module vga_ser_mux
  import vga_ser_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [PLANES*BYTE_W-1:0]     planes_in,
  input  logic [$clog2(BYTE_W)-1:0]    cnt,
  input  fmt_e                         fmt,
  output logic [PLANES-1:0]            pix
);

  localparam int BIT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] bytes_q [PLANES];
  logic [PLANES-1:0] planar_pix;
  logic [PLANES-1:0] oe_pix;
  logic [BIT_W-1:0]  pos_planar;
  logic [BIT_W-2:0]  pair;
  logic              half;
  logic [BIT_W-1:0]  pos_odd;
  logic [BIT_W-1:0]  pos_even;
  logic [BYTE_W-1:0] lo_byte;
  logic [BYTE_W-1:0] hi_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PLANES; p++) bytes_q[p] <= '0;
    end else if (load) begin
      for (int p = 0; p < PLANES; p++) bytes_q[p] <= planes_in[p*BYTE_W +: BYTE_W];
    end
  end

  // Most significant bit first: position = BYTE_W-1-cnt.
  assign pos_planar = ~cnt;

  for (genvar n = 0; n < PLANES; n++) begin : g_planar
    assign planar_pix[n] = bytes_q[n][pos_planar];

    AST_BYTE_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (bytes_q[n] == $past(planes_in[n*BYTE_W +: BYTE_W]))); // R3
  end

  // Interleaved: pair index in the low bits, half select on the top bit.
  assign pair     = cnt[BIT_W-2:0];
  assign half     = cnt[BIT_W-1];
  assign pos_odd  = {~pair, 1'b1};
  assign pos_even = {~pair, 1'b0};
  assign lo_byte  = half ? bytes_q[1] : bytes_q[0];
  assign hi_byte  = half ? bytes_q[3] : bytes_q[2];

  always_comb begin
    oe_pix[0] = lo_byte[pos_even];
    oe_pix[1] = lo_byte[pos_odd];
    oe_pix[2] = hi_byte[pos_even];
    oe_pix[3] = hi_byte[pos_odd];
  end

  assign pix = (fmt == FMT_ODDEVEN) ? oe_pix : planar_pix;

endmodule

// File: rtl/vga_plane_serializer.sv
module vga_plane_serializer
  import vga_ser_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 8,
  parameter int MODE_IDX  = 5,
  parameter int FIELD_LSB = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic                     cfg_sel,
  input  logic [DATA_W-1:0]        cfg_wdata,
  output logic [DATA_W-1:0]        cfg_rdata,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [PLANES*BYTE_W-1:0] in_planes,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [PLANES-1:0]        out_pix
);

  localparam int CNT_W = $clog2(BYTE_W);

  fmt_e             fmt_live;
  fmt_e             fmt_grp;
  logic             load;
  logic [CNT_W-1:0] cnt;

  vga_ser_cfg #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .MODE_IDX(MODE_IDX), .FIELD_LSB(FIELD_LSB)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .sel(cfg_sel),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .fmt(fmt_live)
  );

  vga_ser_seq #(.GROUP(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .fmt_in(fmt_live),
    .load(load), .cnt(cnt), .fmt_q(fmt_grp)
  );

  vga_ser_mux #(.BYTE_W(BYTE_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .load(load), .planes_in(in_planes),
    .cnt(cnt), .fmt(fmt_grp), .pix(out_pix)
  );

  AST_PIX_HELD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix))); // R8

endmodule

// File: tb/vga_plane_serializer_tb.sv
module vga_plane_serializer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_planes = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [3:0]  out_pix;

  int n_chk = 0;
  int n_err = 0;
  bit chk_on = 1'b0;
  bit feed_en = 1'b0;
  bit r10_phase = 1'b0;
  int rdy_pct = 100;

  // Behavioural reference state.
  logic [3:0] qv[$];
  string      qt[$];
  logic [7:0] m_idx = '0;
  logic [7:0] m_reg = '0;

  always #2.5 clk = ~clk; // 200 MHz

  vga_plane_serializer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_planes(in_planes), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  // Reference model: advances on each edge from bench-driven inputs only.
  always @(posedge clk) begin
    if (rst_n) begin
      bit fire, rdy, ld;
      logic [7:0] pl [4];
      int f;
      fire = (qv.size() > 0) && out_ready;
      rdy  = (qv.size() == 0) || (qv.size() == 1 && out_ready);
      ld   = in_valid && rdy;
      if (fire) begin
        void'(qv.pop_front());
        void'(qt.pop_front());
      end
      if (ld) begin
        for (int p = 0; p < 4; p++) pl[p] = in_planes[p*8 +: 8];
        f = int'(m_reg[6:5]);
        for (int k = 0; k < 8; k++) begin
          logic [3:0] nib;
          string tg;
          if (f == 1) begin
            int pr, lo, hi;
            pr = k % 4;
            lo = (k < 4) ? 0 : 1;
            hi = lo + 2;
            nib[1] = pl[lo][7-2*pr];
            nib[0] = pl[lo][6-2*pr];
            nib[3] = pl[hi][7-2*pr];
            nib[2] = pl[hi][6-2*pr];
            tg = (k < 4) ? "R5" : "R6";
          end else begin
            for (int n = 0; n < 4; n++) nib[n] = pl[n][7-k];
            if (f != 0) tg = "R7";
            else if (m_reg != 8'h00) tg = "R11";
            else tg = "R4";
          end
          if (r10_phase) tg = "R10";
          qv.push_back(nib);
          qt.push_back(tg);
        end
      end
      if (cfg_we) begin
        if (!cfg_sel) m_idx = cfg_wdata;
        else if (m_idx == 8'd5) m_reg = cfg_wdata;
      end
    end
  end

  // Per-cycle comparison, sampled after the edge has settled.
  always @(posedge clk) begin
    #2;
    if (rst_n && chk_on) begin
      bit exp_v, exp_r;
      exp_v = (qv.size() > 0);
      exp_r = (qv.size() == 0) || (qv.size() == 1 && out_ready);
      chk(out_valid == exp_v, "R3/R8 out_valid", int'(out_valid), int'(exp_v));
      chk(in_ready == exp_r, "R9 in_ready", int'(in_ready), int'(exp_r));
      if (exp_v && out_valid) chk(out_pix == qv[0], qt[0], int'(out_pix), int'(qv[0]));
    end
  end

  // Stream driver.
  always @(negedge clk) begin
    if (feed_en) begin
      in_valid  = (rdy_pct == 100) ? 1'b1 : (($urandom % 4) != 0);
      in_planes = $urandom;
      out_ready = int'($urandom % 100) < rdy_pct;
    end else begin
      in_valid  = 1'b0;
      out_ready = 1'b1;
    end
  end

  task automatic cfg_write(input bit s, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input logic [7:0] mode, input int pct, input int cycles);
    cfg_write(1'b1, mode);
    rdy_pct = pct;
    feed_en = 1'b1;
    repeat (cycles) @(negedge clk);
    feed_en = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #2;
    // R1: reset state
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    cfg_sel = 1'b0; #0.1;
    chk(cfg_rdata == 8'h00, "R1 index", int'(cfg_rdata), 0);
    cfg_sel = 1'b1; #0.1;
    chk(cfg_rdata == 8'h00, "R1 mode reg", int'(cfg_rdata), 0);
    chk_on = 1'b1;

    // R2: register access through index/data ports
    cfg_write(1'b0, 8'h05);
    cfg_write(1'b1, 8'hFF);
    cfg_sel = 1'b1; #1;
    chk(cfg_rdata == 8'hFF, "R2 data readback", int'(cfg_rdata), 'hFF);
    cfg_write(1'b0, 8'h03);
    cfg_write(1'b1, 8'h12);
    cfg_sel = 1'b1; #1;
    chk(cfg_rdata == 8'h00, "R2 foreign index read", int'(cfg_rdata), 0);
    cfg_sel = 1'b0; #1;
    chk(cfg_rdata == 8'h03, "R2 index readback", int'(cfg_rdata), 3);
    cfg_write(1'b0, 8'h05);
    cfg_sel = 1'b1; #1;
    chk(cfg_rdata == 8'hFF, "R2 foreign write ignored", int'(cfg_rdata), 'hFF);
    cfg_write(1'b1, 8'h00);

    run(8'h00, 100, 80);   // R4 back to back
    run(8'h20, 100, 80);   // R5 R6 back to back
    run(8'h20, 55, 200);   // R5 R6 R8 stalls
    run(8'h00, 40, 150);   // R4 R8 heavy stalls
    run(8'h40, 80, 100);   // R7
    run(8'h60, 80, 100);   // R7
    run(8'h9F, 80, 100);   // R11 field 00, other bits set

    // R10: format rewritten while groups run
    r10_phase = 1'b1;
    rdy_pct = 70;
    feed_en = 1'b1;
    for (int i = 0; i < 30; i++) begin
      cfg_write(1'b1, (i % 2 == 0) ? 8'h20 : 8'h00);
      repeat (3) @(negedge clk);
    end
    feed_en = 1'b0;
    repeat (12) @(negedge clk);
    r10_phase = 1'b0;

    summary();
    $finish;
  end

endmodule